// File: doc/BRIEF.md
# Event-to-Interrupt Aggregation Controller

This block collects single-cycle event strobes from many sources and turns them into three level-sensitive interrupt requests. Every event arrives as a 7-bit code with a valid strobe. The code names one bit out of 96 pending flags, which are held in three 32-bit words. Once set, a pending flag stays set until software clears it.

Each interrupt line has its own set of enable masks, one mask per pending word. A line is high while at least one pending flag in any word is also enabled in that line's mask. Software clears pending flags by writing ones to them. The line falls once nothing enabled is left anywhere. Line 0 is meant for interrupt level 13, line 1 for level 11 and line 2 for level 9.

Software uses a flat register bus. Reads are combinational. A write takes effect at the clock edge.

Top module: `evt_irq_aggr`

## Requirements
- R1: After the active-low asynchronous reset, every pending word and every mask reads 0 and all three `irq_o` bits are 0.
- R2: A valid event whose code has bits 6:5 equal to w (0..2) sets bit `code[4:0]` of pending word w at the next clock edge. Other pending bits do not change.
- R3: A valid event whose code has bits 6:5 equal to 3 changes no pending bit and no interrupt line.
- R4: A bus write to pending word w clears exactly the bits that are 1 in `bus_wdata_i`. All other bits of that word keep their values.
- R5: Bus address bits 3:2 select the bank: 0 is pending, 1 is the line-0 mask, 2 is the line-1 mask and 3 is the line-2 mask. Address bits 1:0 select word 0..2. A mask write stores the data and a read returns it. Word index 3 reads 0 and ignores writes.
- R6: `irq_o[k]` is 1 exactly when some word w has a nonzero value of (pending[w] AND mask k[w]). This holds from the cycle after the edge that updated the pending or mask registers.
- R7: A line stays high while any masked pending bit remains in any of the three words. It falls only after the last such bit is cleared or unmasked.
- R8: If an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: Reading a pending word has no side effect. Repeated reads return the same value.
- R10: The three lines are independent. A bit enabled only in the line-0 mask raises only `irq_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event strobe |
| evt_code_i | input | 7 | Event code: bits 6:5 select the word, bits 4:0 select the bit |
| bus_we_i | input | 1 | Bus write enable |
| bus_addr_i | input | 4 | Register address: {bank, word} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 3 | Interrupt lines 0, 1 and 2 (levels 13, 11 and 9) |

## Verification
Two operations can land on the same pending bit in one cycle: an arriving event that sets it and a software write that clears it. The bench drives both together on the same bit, directed and again at random. It expects the bit to read back as set and the affected line to stay high. A mask write can also coincide with an event. The bench's reference model applies the clear or mask update first and the event second, and the line level is compared in the following cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NUM_LINES = 3;
  localparam int BANK_W    = 2;

  typedef enum logic [BANK_W-1:0] {
    BANK_PEND  = 2'd0,
    BANK_MASK0 = 2'd1,
    BANK_MASK1 = 2'd2,
    BANK_MASK2 = 2'd3
  } bank_e;
endpackage

// File: rtl/evt_pend_regs.sv
module evt_pend_regs #(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int WSEL_W    = 2,
  parameter int BIT_W     = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                evt_valid_i,
  input  logic [WSEL_W-1:0]                   evt_word_i,
  input  logic [BIT_W-1:0]                    evt_bit_i,
  input  logic [NUM_WORDS-1:0]                clr_en_i,
  input  logic [WORD_W-1:0]                   clr_bits_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]    pend_o
);
  logic [WORD_W-1:0] onehot;
  assign onehot = WORD_W'(1) << evt_bit_i;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] set_v, clr_v;
    assign set_v = (evt_valid_i && evt_word_i == WSEL_W'(w)) ? onehot : '0;
    assign clr_v = clr_en_i[w] ? clr_bits_i : '0;
    // set applied after clear: an event wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[w] <= '0;
      else         pend_o[w] <= (pend_o[w] & ~clr_v) | set_v;
    end
  end
endmodule

// File: rtl/evt_mask_regs.sv
module evt_mask_regs #(
  parameter int NUM_LINES = 3,
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32
) (
  input  logic                                               clk_i,
  input  logic                                               rst_ni,
  input  logic [NUM_LINES-1:0][NUM_WORDS-1:0]                we_i,
  input  logic [WORD_W-1:0]                                  wdata_i,
  output logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0]    mask_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        mask_o[l][w] <= '0;
        else if (we_i[l][w]) mask_o[l][w] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce #(
  parameter int NUM_LINES = 3,
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]                 pend_i,
  input  logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0]  mask_i,
  output logic [NUM_LINES-1:0]                             irq_o
);
  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      logic acc;
      acc = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++) acc = acc | (|(pend_i[w] & mask_i[l][w]));
      irq_o[l] = acc;
    end
  end
endmodule

// File: rtl/evt_irq_aggr.sv
module evt_irq_aggr
  import evt_irq_pkg::*;
#(
  parameter  int WORD_W    = 32,
  parameter  int NUM_WORDS = 3,
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int WSEL_W    = $clog2(NUM_WORDS + 1),
  localparam int CODE_W    = WSEL_W + BIT_W,
  localparam int ADDR_W    = BANK_W + WSEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_valid_i,
  input  logic [CODE_W-1:0]    evt_code_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [WORD_W-1:0]    bus_wdata_i,
  output logic [WORD_W-1:0]    bus_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0]                 pend_q;
  logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0]  mask_q;
  logic [NUM_WORDS-1:0]                             clr_en;
  logic [NUM_LINES-1:0][NUM_WORDS-1:0]              mask_we;
  bank_e                                            bank;
  logic [WSEL_W-1:0]                                word;

  assign bank = bank_e'(bus_addr_i[ADDR_W-1 -: BANK_W]);
  assign word = bus_addr_i[WSEL_W-1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    assign clr_en[w] = bus_we_i && bank == BANK_PEND && word == WSEL_W'(w);
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      assign mask_we[l][w] = bus_we_i && bank == bank_e'(BANK_W'(l + 1)) && word == WSEL_W'(w);
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word == WSEL_W'(w)) begin
        if (bank == BANK_PEND) bus_rdata_o = pend_q[w];
        for (int l = 0; l < NUM_LINES; l++)
          if (bank == bank_e'(BANK_W'(l + 1))) bus_rdata_o = mask_q[l][w];
      end
    end
  end

  evt_pend_regs #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .WSEL_W(WSEL_W), .BIT_W(BIT_W)
  ) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_valid_i(evt_valid_i),
    .evt_word_i (evt_code_i[CODE_W-1 -: WSEL_W]),
    .evt_bit_i  (evt_code_i[BIT_W-1:0]),
    .clr_en_i   (clr_en),
    .clr_bits_i (bus_wdata_i),
    .pend_o     (pend_q)
  );

  evt_mask_regs #(
    .NUM_LINES(NUM_LINES), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
  ) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .wdata_i(bus_wdata_i),
    .mask_o (mask_q)
  );

  evt_irq_reduce #(
    .NUM_LINES(NUM_LINES), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
  ) u_reduce (
    .pend_i(pend_q),
    .mask_i(mask_q),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/evt_irq_aggr_chk.sv
module evt_irq_aggr_chk #(
  parameter  int WORD_W    = 32,
  parameter  int NUM_WORDS = 3,
  parameter  int NUM_LINES = 3,
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int WSEL_W    = $clog2(NUM_WORDS + 1),
  localparam int CODE_W    = WSEL_W + BIT_W,
  localparam int ADDR_W    = 2 + WSEL_W,
  localparam int FLAT_W    = NUM_WORDS * WORD_W,
  localparam int IDX_W     = $clog2(FLAT_W + WORD_W)
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              evt_valid_i,
  input logic [CODE_W-1:0]                 evt_code_i,
  input logic                              bus_we_i,
  input logic [ADDR_W-1:0]                 bus_addr_i,
  input logic [WORD_W-1:0]                 bus_wdata_i,
  input logic [NUM_LINES-1:0]              irq_o,
  input logic [NUM_WORDS-1:0][WORD_W-1:0]  pend_q
);
  logic [FLAT_W-1:0] flat;
  logic [IDX_W-1:0]  evt_idx;
  logic [WSEL_W-1:0] evt_word;
  logic              evt_ok, pend_wr;

  assign flat     = pend_q;
  assign evt_word = evt_code_i[CODE_W-1 -: WSEL_W];
  assign evt_ok   = evt_valid_i && (int'(evt_word) < NUM_WORDS);
  assign evt_idx  = IDX_W'(int'(evt_word) * WORD_W + int'(evt_code_i[BIT_W-1:0]));
  assign pend_wr  = bus_we_i && bus_addr_i[ADDR_W-1 -: 2] == 2'd0;

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_ok |=> flat[$past(evt_idx)]);

  assert_bad_code_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !evt_ok && !bus_we_i) |=> $stable(pend_q));

  assert_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_ok && pend_wr && bus_addr_i[WSEL_W-1:0] == evt_word) |=> flat[$past(evt_idx)]);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
    assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_wr && bus_addr_i[WSEL_W-1:0] == WSEL_W'(w) && !evt_valid_i)
      |=> pend_q[w] == ($past(pend_q[w]) & ~$past(bus_wdata_i)));
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_l
    assert_rise_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[l]) |-> ($past(evt_valid_i) || $past(bus_we_i)));
    assert_fall_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[l]) |-> $past(bus_we_i));
  end
endmodule

bind evt_irq_aggr evt_irq_aggr_chk #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_LINES(evt_irq_pkg::NUM_LINES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_valid_i(evt_valid_i),
  .evt_code_i (evt_code_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .pend_q     (pend_q)
);

// File: tb/evt_irq_aggr_tb.sv
module evt_irq_aggr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [6:0]  evt_code = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] pm [3];
  logic [31:0] mm [3][3];

  always #10 clk = ~clk;

  evt_irq_aggr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_code_i(evt_code),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  function automatic logic [2:0] exp_irq();
    logic [2:0] r = '0;
    for (int l = 0; l < 3; l++)
      for (int w = 0; w < 3; w++)
        if ((pm[w] & mm[l][w]) != 0) r[l] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    if (a[1:0] == 2'd3) return '0;
    if (a[3:2] == 2'd0) return pm[a[1:0]];
    return mm[a[3:2]-1][a[1:0]];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp_rd(a));
  endtask

  task automatic model(input logic v, input logic [6:0] c, input logic we,
                       input logic [3:0] a, input logic [31:0] d);
    if (we && a[1:0] != 2'd3) begin
      if (a[3:2] == 2'd0) pm[a[1:0]] = pm[a[1:0]] & ~d;
      else                mm[a[3:2]-1][a[1:0]] = d;
    end
    if (v && c[6:5] != 2'd3) pm[c[6:5]][c[4:0]] = 1'b1;
  endtask

  task automatic cyc(input string tag, input logic v, input logic [6:0] c, input logic we,
                     input logic [3:0] a, input logic [31:0] d);
    evt_valid = v; evt_code = c; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model(v, c, we, a, d);
    @(negedge clk);
    evt_valid = 1'b0; bus_we = 1'b0;
    chk(tag, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int w = 0; w < 3; w++) begin
      pm[w] = '0;
      for (int l = 0; l < 3; l++) mm[l][w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) rd_chk("R1", 4'(a));
    chk("R1", 32'(irq), 32'h0);

    // R5 mask write/read, word index 3 ignored
    cyc("R5", 0, '0, 1, 4'b0100, 32'h0000_0010);
    rd_chk("R5", 4'b0100);
    cyc("R5", 0, '0, 1, 4'b0111, 32'hFFFF_FFFF);
    rd_chk("R5", 4'b0111);

    // R2 event sets word0 bit4, raises line 0 only (R10)
    cyc("R2", 1, {2'd0, 5'd4}, 0, '0, '0);
    rd_chk("R2", 4'b0000);
    chk("R10", 32'(irq), 32'h1);

    // R9 repeated reads
    rd_chk("R9", 4'b0000);
    rd_chk("R9", 4'b0000);
    chk("R9", 32'(irq), 32'h1);

    // R3 word select 3 ignored
    cyc("R3", 1, {2'd3, 5'd3}, 0, '0, '0);
    for (int a = 0; a < 3; a++) rd_chk("R3", 4'(a));

    // R7 line holds while another word still has an enabled bit
    cyc("R7", 0, '0, 1, 4'b0110, 32'h0000_0001);
    cyc("R7", 1, {2'd2, 5'd0}, 0, '0, '0);
    cyc("R7", 0, '0, 1, 4'b0000, 32'h0000_0010);
    chk("R7", 32'(irq[0]), 32'h1);
    cyc("R7", 0, '0, 1, 4'b0010, 32'h0000_0001);
    chk("R7", 32'(irq[0]), 32'h0);

    // R4 write-one-to-clear
    cyc("R4", 1, {2'd1, 5'd1}, 0, '0, '0);
    cyc("R4", 1, {2'd1, 5'd2}, 0, '0, '0);
    cyc("R4", 1, {2'd1, 5'd3}, 0, '0, '0);
    cyc("R4", 0, '0, 1, 4'b0001, 32'h0000_0004);
    chk("R4", exp_rd(4'b0001), 32'h0000_000A);
    rd_chk("R4", 4'b0001);

    // R8 event and clear on the same bit in the same cycle
    cyc("R8", 1, {2'd1, 5'd1}, 1, 4'b0001, 32'h0000_0002);
    bus_addr = 4'b0001; #1;
    chk("R8", 32'(bus_rdata[1]), 32'h1);

    // R6 mask change takes effect on next cycle, line 2 only
    cyc("R6", 0, '0, 1, 4'b1101, 32'h0000_0008);
    chk("R6", 32'(irq), 32'h4);
    cyc("R7", 0, '0, 1, 4'b1101, 32'h0000_0000);
    chk("R7", 32'(irq[2]), 32'h0);

    // R6 random mix, including coincident event/clear
    for (int i = 0; i < 4000; i++) begin
      logic       v  = ($urandom % 2) == 0;
      logic [6:0] c  = 7'($urandom);
      logic       we = ($urandom % 3) == 0;
      logic [3:0] a  = 4'($urandom);
      logic [31:0] d = $urandom & $urandom & $urandom;
      if (($urandom % 8) == 0 && v) a = {2'd0, c[6:5]};
      cyc("R6", v, c, we, a, d);
      rd_chk("R5", 4'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule